// File: doc/BRIEF.md
# CAN Message-Object Interface Transfer

This block holds the message objects of a CAN controller in a small register-based store. Software reaches the objects through an interface register image: one set of inputs that carries the fields to be written, and one set of outputs that holds the fields most recently read. A command names a 1-based object number, a direction, and a set of field selects. After a fixed transfer delay, exactly the selected fields have moved between the image and the chosen object.

A read can also clear two flags of the object as part of the same transfer: the pending-interrupt flag and the new-data flag. Write transfers can raise a transmit request. The block also publishes a per-object valid vector and a transmit-request vector. It also names the lowest unused receive object in the upper half of the store, which software uses to pick the slot for a new receive filter.

Top module: `canobj_ifxfer`

## Requirements
- R1: A command with `cmd_valid` high, `busy` low and a legal number is accepted on that rising edge. `busy` is then high for exactly two cycles. The transfer result is visible once `busy` has fallen, after the third rising edge counted from acceptance.
- R2: A command presented while `busy` is high is ignored and changes no object.
- R3: A command number of 0, or one above `NUM_OBJ`, is rejected. `busy` stays low and no object, status vector or read field changes.
- R4: A write with the arbitration select (`cmd_sel` bit 5) copies the valid bit, the direction bit, the extended flag and the identifier. When the extended flag is 0, only identifier bits [10:0] are stored and bits [28:11] are stored as zero.
- R5: A write with the control select (`cmd_sel` bit 4) copies the length code, both interrupt enables, the use-mask bit, the end-of-block bit, the pending flag, the new-data flag and the transmit request.
- R6: A write with the mask select (bit 6), the data-A select (bit 1) or the data-B select (bit 0) copies only that field. Every field whose select is clear keeps its stored value.
- R7: A write with bit 2 of `cmd_sel` set forces the object's transmit request to 1. Bit 3 has no effect on a write.
- R8: A read copies only the selected fields (arbitration, control, mask, data A, data B, same bit positions as for a write) from the object to the `rd_*` outputs. Unselected `rd_*` fields hold their values.
- R9: A read with bit 3 of `cmd_sel` set clears the object's pending flag. A control field read in the same command returns the value from before the clear.
- R10: A read with bit 2 of `cmd_sel` set clears the object's new-data flag. A control field read in the same command returns the value from before the clear.
- R11: Bit i of `valid_stat` and of `txrq_stat` shows the valid bit and the transmit request of object i+1.
- R12: `free_rx_num` is the lowest object number from `NUM_OBJ`/2+1 to `NUM_OBJ`-1 whose valid bit is 0. It is `NUM_OBJ` when all of those objects are valid.
- R13: Reset clears every object and every `rd_*` output. After reset `busy` is 0 and `free_rx_num` is `NUM_OBJ`/2+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_write | input | 1 | 1 = image to object, 0 = object to image |
| cmd_sel | input | 7 | Field selects: 6 mask, 5 arbitration, 4 control, 3 clear pending, 2 transmit request / clear new data, 1 data A, 0 data B |
| cmd_num | input | NUM_W | 1-based object number |
| wr_msgval | input | 1 | Image valid bit |
| wr_dir | input | 1 | Image direction bit |
| wr_xtd | input | 1 | Image extended-identifier flag |
| wr_id | input | 29 | Image identifier |
| wr_mask | input | 29 | Image acceptance mask |
| wr_dlc | input | 4 | Image length code |
| wr_txie | input | 1 | Image transmit interrupt enable |
| wr_rxie | input | 1 | Image receive interrupt enable |
| wr_umask | input | 1 | Image use-mask bit |
| wr_eob | input | 1 | Image end-of-block bit |
| wr_intpnd | input | 1 | Image pending flag |
| wr_newdat | input | 1 | Image new-data flag |
| wr_txrq | input | 1 | Image transmit request |
| wr_data_a | input | 32 | Image data bytes 0..3 |
| wr_data_b | input | 32 | Image data bytes 4..7 |
| busy | output | 1 | Transfer in progress |
| rd_msgval | output | 1 | Read valid bit |
| rd_dir | output | 1 | Read direction bit |
| rd_xtd | output | 1 | Read extended flag |
| rd_id | output | 29 | Read identifier |
| rd_mask | output | 29 | Read acceptance mask |
| rd_dlc | output | 4 | Read length code |
| rd_txie | output | 1 | Read transmit interrupt enable |
| rd_rxie | output | 1 | Read receive interrupt enable |
| rd_umask | output | 1 | Read use-mask bit |
| rd_eob | output | 1 | Read end-of-block bit |
| rd_intpnd | output | 1 | Read pending flag |
| rd_newdat | output | 1 | Read new-data flag |
| rd_txrq | output | 1 | Read transmit request |
| rd_data_a | output | 32 | Read data bytes 0..3 |
| rd_data_b | output | 32 | Read data bytes 4..7 |
| valid_stat | output | NUM_OBJ | Per-object valid bits |
| txrq_stat | output | NUM_OBJ | Per-object transmit requests |
| free_rx_num | output | NUM_W | Lowest unused upper-half receive object |

## Verification
An accepted command raises `busy` after its accepting edge. The object store, the `rd_*` outputs, both status vectors and `free_rx_num` all change together on the second edge after that, so they are due three edges after the command was presented. The bench keeps a behavioural model that advances on rising edges with the same three-edge latency. It compares every output on each falling edge, so no result is read during the edge where it changes. Directed checks are taken only after `busy` is seen low on a falling edge. For rejected or ignored commands, the checks are taken on the falling edges that follow.

// File: rtl/canobj_pkg.sv
package canobj_pkg;
   localparam int ID_BITS   = 29;
   localparam int STD_BITS  = 11;
   localparam int HALF_BITS = 32;
   localparam int DLC_BITS  = 4;
   localparam int SEL_BITS  = 7;

   // select bit positions inside a command
   localparam int SEL_DB   = 0;
   localparam int SEL_DA   = 1;
   localparam int SEL_TXND = 2;
   localparam int SEL_CLRP = 3;
   localparam int SEL_CTL  = 4;
   localparam int SEL_ARB  = 5;
   localparam int SEL_MSK  = 6;

   typedef struct packed {
      logic                 msgval;
      logic                 dir;
      logic                 xtd;
      logic [ID_BITS-1:0]   id;
      logic [ID_BITS-1:0]   mask;
      logic [DLC_BITS-1:0]  dlc;
      logic                 txie;
      logic                 rxie;
      logic                 umask;
      logic                 eob;
      logic                 intpnd;
      logic                 newdat;
      logic                 txrq;
      logic [HALF_BITS-1:0] data_a;
      logic [HALF_BITS-1:0] data_b;
   } msgobj_t;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FETCH  = 2'd1,
      ST_COMMIT = 2'd2
   } xfer_st_e;
endpackage

// File: rtl/canobj_ctrl.sv
module canobj_ctrl
   import canobj_pkg::*;
#(
   parameter int NUM_OBJ = 16,
   parameter int NUM_W   = $clog2(NUM_OBJ + 2),
   parameter int IDX_W   = $clog2(NUM_OBJ)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   input  logic                cmd_write,
   input  logic [SEL_BITS-1:0] cmd_sel,
   input  logic [NUM_W-1:0]    cmd_num,
   output logic                busy,
   output logic                accept,
   output logic                fetch_en,
   output logic                commit_en,
   output logic                lat_write,
   output logic [SEL_BITS-1:0] lat_sel,
   output logic [IDX_W-1:0]    lat_idx
);
   localparam logic [NUM_W-1:0] MAX_NUM = NUM_W'(NUM_OBJ);

   xfer_st_e st;
   logic     num_ok;

   assign num_ok    = (cmd_num != '0) && (cmd_num <= MAX_NUM);
   assign accept    = (st == ST_IDLE) && cmd_valid && num_ok;
   assign busy      = (st != ST_IDLE);
   assign fetch_en  = (st == ST_FETCH);
   assign commit_en = (st == ST_COMMIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         lat_write <= 1'b0;
         lat_sel   <= '0;
         lat_idx   <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (accept) begin
                  st        <= ST_FETCH;
                  lat_write <= cmd_write;
                  lat_sel   <= cmd_sel;
                  lat_idx   <= IDX_W'(cmd_num - 1'b1);
               end
            end
            ST_FETCH:  st <= ST_COMMIT;
            ST_COMMIT: st <= ST_IDLE;
            default:   st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/canobj_store.sv
module canobj_store
   import canobj_pkg::*;
#(
   parameter int NUM_OBJ = 16,
   parameter int IDX_W   = $clog2(NUM_OBJ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [IDX_W-1:0]   waddr,
   input  msgobj_t            wdata,
   input  logic [IDX_W-1:0]   raddr,
   output msgobj_t            rdata,
   output logic [NUM_OBJ-1:0] valid_vec,
   output logic [NUM_OBJ-1:0] txrq_vec
);
   msgobj_t mem [NUM_OBJ];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_OBJ; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

   for (genvar g = 0; g < NUM_OBJ; g++) begin : g_stat
      assign valid_vec[g] = mem[g].msgval;
      assign txrq_vec[g]  = mem[g].txrq;
   end
endmodule

// File: rtl/canobj_merge.sv
module canobj_merge
   import canobj_pkg::*;
#(
   parameter bit STD_ZERO_FILL = 1'b1
) (
   input  logic                is_write,
   input  logic [SEL_BITS-1:0] sel,
   input  msgobj_t             obj_cur,
   input  msgobj_t             img,
   input  msgobj_t             rd_cur,
   output msgobj_t             obj_next,
   output msgobj_t             rd_next
);
   logic [ID_BITS-1:0] id_store;

   // identifier as stored: short form keeps only the low bits
   if (STD_ZERO_FILL) begin : g_std_fill
      assign id_store = img.xtd ? img.id
                                : {{(ID_BITS-STD_BITS){1'b0}}, img.id[STD_BITS-1:0]};
   end else begin : g_std_raw
      assign id_store = img.id;
   end

   always_comb begin
      obj_next = obj_cur;
      rd_next  = rd_cur;
      if (is_write) begin
         if (sel[SEL_ARB]) begin
            obj_next.msgval = img.msgval;
            obj_next.dir    = img.dir;
            obj_next.xtd    = img.xtd;
            obj_next.id     = id_store;
         end
         if (sel[SEL_CTL]) begin
            obj_next.dlc    = img.dlc;
            obj_next.txie   = img.txie;
            obj_next.rxie   = img.rxie;
            obj_next.umask  = img.umask;
            obj_next.eob    = img.eob;
            obj_next.intpnd = img.intpnd;
            obj_next.newdat = img.newdat;
            obj_next.txrq   = img.txrq;
         end
         if (sel[SEL_MSK]) obj_next.mask   = img.mask;
         if (sel[SEL_DA])  obj_next.data_a = img.data_a;
         if (sel[SEL_DB])  obj_next.data_b = img.data_b;
         if (sel[SEL_TXND]) obj_next.txrq  = 1'b1;
      end else begin
         if (sel[SEL_ARB]) begin
            rd_next.msgval = obj_cur.msgval;
            rd_next.dir    = obj_cur.dir;
            rd_next.xtd    = obj_cur.xtd;
            rd_next.id     = obj_cur.id;
         end
         if (sel[SEL_CTL]) begin
            rd_next.dlc    = obj_cur.dlc;
            rd_next.txie   = obj_cur.txie;
            rd_next.rxie   = obj_cur.rxie;
            rd_next.umask  = obj_cur.umask;
            rd_next.eob    = obj_cur.eob;
            rd_next.intpnd = obj_cur.intpnd;
            rd_next.newdat = obj_cur.newdat;
            rd_next.txrq   = obj_cur.txrq;
         end
         if (sel[SEL_MSK]) rd_next.mask   = obj_cur.mask;
         if (sel[SEL_DA])  rd_next.data_a = obj_cur.data_a;
         if (sel[SEL_DB])  rd_next.data_b = obj_cur.data_b;
         if (sel[SEL_CLRP]) obj_next.intpnd = 1'b0;
         if (sel[SEL_TXND]) obj_next.newdat = 1'b0;
      end
   end
endmodule

// File: rtl/canobj_rxscan.sv
module canobj_rxscan #(
   parameter int NUM_OBJ  = 16,
   parameter int NUM_W    = $clog2(NUM_OBJ + 2),
   parameter int LO_NUM   = NUM_OBJ / 2 + 1,
   parameter int SCAN_CNT = NUM_OBJ - LO_NUM
) (
   input  logic [SCAN_CNT-1:0] scan_valid,
   output logic [NUM_W-1:0]    free_num
);
   // scan_valid[k] belongs to object LO_NUM + k
   logic [NUM_W-1:0] chain [SCAN_CNT+1];

   assign chain[SCAN_CNT] = NUM_W'(NUM_OBJ);
   for (genvar k = SCAN_CNT - 1; k >= 0; k--) begin : g_pick
      assign chain[k] = scan_valid[k] ? chain[k+1] : NUM_W'(LO_NUM + k);
   end
   assign free_num = chain[0];
endmodule

// File: rtl/canobj_ifxfer.sv
module canobj_ifxfer
   import canobj_pkg::*;
#(
   parameter int NUM_OBJ = 16,
   localparam int NUM_W  = $clog2(NUM_OBJ + 2),
   localparam int IDX_W  = $clog2(NUM_OBJ),
   localparam int HALF   = NUM_OBJ / 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic                 cmd_write,
   input  logic [SEL_BITS-1:0]  cmd_sel,
   input  logic [NUM_W-1:0]     cmd_num,
   input  logic                 wr_msgval,
   input  logic                 wr_dir,
   input  logic                 wr_xtd,
   input  logic [ID_BITS-1:0]   wr_id,
   input  logic [ID_BITS-1:0]   wr_mask,
   input  logic [DLC_BITS-1:0]  wr_dlc,
   input  logic                 wr_txie,
   input  logic                 wr_rxie,
   input  logic                 wr_umask,
   input  logic                 wr_eob,
   input  logic                 wr_intpnd,
   input  logic                 wr_newdat,
   input  logic                 wr_txrq,
   input  logic [HALF_BITS-1:0] wr_data_a,
   input  logic [HALF_BITS-1:0] wr_data_b,
   output logic                 busy,
   output logic                 rd_msgval,
   output logic                 rd_dir,
   output logic                 rd_xtd,
   output logic [ID_BITS-1:0]   rd_id,
   output logic [ID_BITS-1:0]   rd_mask,
   output logic [DLC_BITS-1:0]  rd_dlc,
   output logic                 rd_txie,
   output logic                 rd_rxie,
   output logic                 rd_umask,
   output logic                 rd_eob,
   output logic                 rd_intpnd,
   output logic                 rd_newdat,
   output logic                 rd_txrq,
   output logic [HALF_BITS-1:0] rd_data_a,
   output logic [HALF_BITS-1:0] rd_data_b,
   output logic [NUM_OBJ-1:0]   valid_stat,
   output logic [NUM_OBJ-1:0]   txrq_stat,
   output logic [NUM_W-1:0]     free_rx_num
);
   if (NUM_OBJ < 4 || (NUM_OBJ % 2) != 0) begin : g_bad_count
      $error("NUM_OBJ must be even and at least 4");
   end
   if ((1 << IDX_W) != NUM_OBJ) begin : g_bad_pow2
      $error("NUM_OBJ must be a power of two");
   end

   msgobj_t wr_img, img_q, held_q, rd_q, mem_rdata, mem_next, rd_next;
   logic                accept, fetch_en, commit_en, lat_write;
   logic [SEL_BITS-1:0] lat_sel;
   logic [IDX_W-1:0]    lat_idx;

   always_comb begin
      wr_img        = '0;
      wr_img.msgval = wr_msgval;
      wr_img.dir    = wr_dir;
      wr_img.xtd    = wr_xtd;
      wr_img.id     = wr_id;
      wr_img.mask   = wr_mask;
      wr_img.dlc    = wr_dlc;
      wr_img.txie   = wr_txie;
      wr_img.rxie   = wr_rxie;
      wr_img.umask  = wr_umask;
      wr_img.eob    = wr_eob;
      wr_img.intpnd = wr_intpnd;
      wr_img.newdat = wr_newdat;
      wr_img.txrq   = wr_txrq;
      wr_img.data_a = wr_data_a;
      wr_img.data_b = wr_data_b;
   end

   canobj_ctrl #(.NUM_OBJ(NUM_OBJ), .NUM_W(NUM_W), .IDX_W(IDX_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_write (cmd_write),
      .cmd_sel   (cmd_sel),
      .cmd_num   (cmd_num),
      .busy      (busy),
      .accept    (accept),
      .fetch_en  (fetch_en),
      .commit_en (commit_en),
      .lat_write (lat_write),
      .lat_sel   (lat_sel),
      .lat_idx   (lat_idx)
   );

   canobj_store #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (commit_en),
      .waddr     (lat_idx),
      .wdata     (mem_next),
      .raddr     (lat_idx),
      .rdata     (mem_rdata),
      .valid_vec (valid_stat),
      .txrq_vec  (txrq_stat)
   );

   canobj_merge #(.STD_ZERO_FILL(1'b1)) u_merge (
      .is_write (lat_write),
      .sel      (lat_sel),
      .obj_cur  (held_q),
      .img      (img_q),
      .rd_cur   (rd_q),
      .obj_next (mem_next),
      .rd_next  (rd_next)
   );

   canobj_rxscan #(.NUM_OBJ(NUM_OBJ), .NUM_W(NUM_W)) u_rxscan (
      .scan_valid (valid_stat[NUM_OBJ-2:HALF]),
      .free_num   (free_rx_num)
   );

   // image sampled at accept, object fetched, then merged and committed
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         img_q  <= '0;
         held_q <= '0;
         rd_q   <= '0;
      end else begin
         if (accept)                 img_q  <= wr_img;
         if (fetch_en)               held_q <= mem_rdata;
         if (commit_en && !lat_write) rd_q  <= rd_next;
      end
   end

   assign rd_msgval = rd_q.msgval;
   assign rd_dir    = rd_q.dir;
   assign rd_xtd    = rd_q.xtd;
   assign rd_id     = rd_q.id;
   assign rd_mask   = rd_q.mask;
   assign rd_dlc    = rd_q.dlc;
   assign rd_txie   = rd_q.txie;
   assign rd_rxie   = rd_q.rxie;
   assign rd_umask  = rd_q.umask;
   assign rd_eob    = rd_q.eob;
   assign rd_intpnd = rd_q.intpnd;
   assign rd_newdat = rd_q.newdat;
   assign rd_txrq   = rd_q.txrq;
   assign rd_data_a = rd_q.data_a;
   assign rd_data_b = rd_q.data_b;
endmodule

// File: rtl/canobj_ifxfer_chk.sv
module canobj_ifxfer_chk #(
   parameter int NUM_OBJ = 16,
   parameter int NUM_W   = $clog2(NUM_OBJ + 2),
   parameter int IDX_W   = $clog2(NUM_OBJ)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid,
   input logic [NUM_W-1:0]   cmd_num,
   input logic               busy,
   input logic [NUM_OBJ-1:0] valid_stat,
   input logic [NUM_OBJ-1:0] txrq_stat,
   input logic [NUM_W-1:0]   free_rx_num,
   input logic [31:0]        rd_data_a,
   input logic [31:0]        rd_data_b,
   input logic [28:0]        rd_id
);
   localparam logic [NUM_W-1:0] MAX_NUM = NUM_W'(NUM_OBJ);
   localparam logic [NUM_W-1:0] LO_NUM  = NUM_W'(NUM_OBJ / 2 + 1);

   logic legal, free_slot_valid;
   assign legal           = cmd_valid && (cmd_num != '0) && (cmd_num <= MAX_NUM);
   assign free_slot_valid = valid_stat[IDX_W'(free_rx_num - 1'b1)];

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && legal) |=> busy);                                     // R1
   AST_BUSY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy);                                          // R1
   AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |=> !busy);                               // R1
   AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !legal) |=> !busy);                                   // R3
   AST_STAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> ($stable(valid_stat) && $stable(txrq_stat)));         // R3
   AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> ($stable(rd_data_a) && $stable(rd_data_b) && $stable(rd_id))); // R8
   AST_FREE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (free_rx_num >= LO_NUM) && (free_rx_num <= MAX_NUM));           // R12
   AST_FREE_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (free_rx_num < MAX_NUM) |-> !free_slot_valid);                  // R12
endmodule

bind canobj_ifxfer canobj_ifxfer_chk #(.NUM_OBJ(NUM_OBJ)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid   (cmd_valid),
   .cmd_num     (cmd_num),
   .busy        (busy),
   .valid_stat  (valid_stat),
   .txrq_stat   (txrq_stat),
   .free_rx_num (free_rx_num),
   .rd_data_a   (rd_data_a),
   .rd_data_b   (rd_data_b),
   .rd_id       (rd_id)
);

// File: tb/canobj_ifxfer_tb.sv
module canobj_ifxfer_tb;
   localparam int NOBJ = 16;
   localparam int NW   = $clog2(NOBJ + 2);
   localparam logic [6:0] S_DB = 7'h01, S_DA = 7'h02, S_TXND = 7'h04,
                          S_CLRP = 7'h08, S_CTL = 7'h10, S_ARB = 7'h20, S_MSK = 7'h40;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_write = 1'b0;
   logic [6:0] cmd_sel = '0;
   logic [NW-1:0] cmd_num = '0;
   logic wr_msgval = 0, wr_dir = 0, wr_xtd = 0;
   logic [28:0] wr_id = '0, wr_mask = '0;
   logic [3:0] wr_dlc = '0;
   logic wr_txie = 0, wr_rxie = 0, wr_umask = 0, wr_eob = 0, wr_intpnd = 0, wr_newdat = 0, wr_txrq = 0;
   logic [31:0] wr_data_a = '0, wr_data_b = '0;
   logic busy, rd_msgval, rd_dir, rd_xtd, rd_txie, rd_rxie, rd_umask, rd_eob, rd_intpnd, rd_newdat, rd_txrq;
   logic [28:0] rd_id, rd_mask;
   logic [3:0] rd_dlc;
   logic [31:0] rd_data_a, rd_data_b;
   logic [NOBJ-1:0] valid_stat, txrq_stat;
   logic [NW-1:0] free_rx_num;

   always #5 clk = ~clk;

   canobj_ifxfer #(.NUM_OBJ(NOBJ)) u_dut (.*);

   int ntest = 0, nfail = 0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      ntest++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   typedef struct {
      bit val, dir, xtd; bit [28:0] id, msk; bit [3:0] dlc;
      bit txie, rxie, umask, eob, ip, nd, tq; bit [31:0] da, db;
   } mobj_t;

   mobj_t m_obj [1:NOBJ];
   mobj_t m_rd, l_img;
   int m_cnt = 0, l_num = 1;
   bit l_wr; bit [6:0] l_sel;

   function automatic mobj_t img_now();
      mobj_t t;
      t.val = wr_msgval; t.dir = wr_dir; t.xtd = wr_xtd; t.id = wr_id; t.msk = wr_mask;
      t.dlc = wr_dlc; t.txie = wr_txie; t.rxie = wr_rxie; t.umask = wr_umask; t.eob = wr_eob;
      t.ip = wr_intpnd; t.nd = wr_newdat; t.tq = wr_txrq; t.da = wr_data_a; t.db = wr_data_b;
      return t;
   endfunction

   function automatic int m_free();
      for (int k = NOBJ / 2 + 1; k < NOBJ; k++) if (!m_obj[k].val) return k;
      return NOBJ;
   endfunction

   task automatic m_apply();
      mobj_t o = m_obj[l_num];
      if (l_wr) begin
         if (l_sel[5]) begin
            o.val = l_img.val; o.dir = l_img.dir; o.xtd = l_img.xtd;
            o.id = l_img.xtd ? l_img.id : (l_img.id & 29'h7FF);
         end
         if (l_sel[4]) begin
            o.dlc = l_img.dlc; o.txie = l_img.txie; o.rxie = l_img.rxie; o.umask = l_img.umask;
            o.eob = l_img.eob; o.ip = l_img.ip; o.nd = l_img.nd; o.tq = l_img.tq;
         end
         if (l_sel[6]) o.msk = l_img.msk;
         if (l_sel[1]) o.da = l_img.da;
         if (l_sel[0]) o.db = l_img.db;
         if (l_sel[2]) o.tq = 1'b1;
      end else begin
         if (l_sel[5]) begin m_rd.val = o.val; m_rd.dir = o.dir; m_rd.xtd = o.xtd; m_rd.id = o.id; end
         if (l_sel[4]) begin
            m_rd.dlc = o.dlc; m_rd.txie = o.txie; m_rd.rxie = o.rxie; m_rd.umask = o.umask;
            m_rd.eob = o.eob; m_rd.ip = o.ip; m_rd.nd = o.nd; m_rd.tq = o.tq;
         end
         if (l_sel[6]) m_rd.msk = o.msk;
         if (l_sel[1]) m_rd.da = o.da;
         if (l_sel[0]) m_rd.db = o.db;
         if (l_sel[3]) o.ip = 1'b0;
         if (l_sel[2]) o.nd = 1'b0;
      end
      m_obj[l_num] = o;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0;
         for (int i = 1; i <= NOBJ; i++) m_obj[i] = '{default: 0};
         m_rd = '{default: 0};
      end else if (m_cnt == 2) m_cnt = 1;
      else if (m_cnt == 1) begin m_apply(); m_cnt = 0; end
      else if (cmd_valid && cmd_num >= 1 && int'(cmd_num) <= NOBJ) begin
         l_wr = cmd_write; l_sel = cmd_sel; l_num = int'(cmd_num); l_img = img_now(); m_cnt = 2;
      end
   end

   // compare every cycle on the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         logic [NOBJ-1:0] ev, et;
         for (int i = 0; i < NOBJ; i++) begin ev[i] = m_obj[i+1].val; et[i] = m_obj[i+1].tq; end
         chk("R1 busy", 64'(busy), 64'(m_cnt != 0));
         chk("R8 rd control/arb", 64'({rd_msgval, rd_dir, rd_xtd, rd_id, rd_dlc, rd_txie, rd_rxie,
                                       rd_umask, rd_eob, rd_intpnd, rd_newdat, rd_txrq}),
             64'({m_rd.val, m_rd.dir, m_rd.xtd, m_rd.id, m_rd.dlc, m_rd.txie, m_rd.rxie,
                  m_rd.umask, m_rd.eob, m_rd.ip, m_rd.nd, m_rd.tq}));
         chk("R8 rd mask", 64'(rd_mask), 64'(m_rd.msk));
         chk("R8 rd data", {rd_data_a, rd_data_b}, {m_rd.da, m_rd.db});
         chk("R11 valid_stat", 64'(valid_stat), 64'(ev));
         chk("R11 txrq_stat", 64'(txrq_stat), 64'(et));
         chk("R12 free_rx_num", 64'(free_rx_num), 64'(m_free()));
      end
   end

   task automatic op(bit w, logic [6:0] sel, int num);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = w; cmd_sel = sel; cmd_num = NW'(num);
      @(negedge clk);
      cmd_valid = 1'b0;
      while (busy) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R13 busy after reset", 64'(busy), 64'd0);
      chk("R13 free after reset", 64'(free_rx_num), 64'd9);
      chk("R13 valid after reset", 64'(valid_stat), 64'd0);
      rst_n = 1'b1;

      // object 3: short identifier with high bits set
      wr_msgval = 1; wr_xtd = 0; wr_id = 29'h1BCD5E7A; wr_mask = 29'h1FFFF800;
      wr_dlc = 4'd8; wr_intpnd = 1; wr_newdat = 1; wr_txie = 1;
      wr_data_a = 32'hA5A50001; wr_data_b = 32'hB6B60002;
      op(1, S_ARB | S_CTL | S_MSK | S_DA | S_DB, 3);
      op(0, S_ARB, 3);
      chk("R4 short id truncated", 64'(rd_id), 64'h67A);
      chk("R4 valid copied", 64'(rd_msgval), 64'd1);

      // object 9: extended identifier
      wr_xtd = 1; wr_id = 29'h1234567;
      op(1, S_ARB, 9);
      chk("R12 free moves past 9", 64'(free_rx_num), 64'd10);
      op(0, S_ARB, 9);
      chk("R4 extended id kept", 64'(rd_id), 64'h1234567);

      // data A alone
      wr_data_a = 32'hC3C30003; wr_data_b = 32'hFFFFFFFF;
      op(1, S_DA, 3);
      op(0, S_DA | S_DB, 3);
      chk("R6 data A written", 64'(rd_data_a), 64'hC3C30003);
      chk("R6 data B kept", 64'(rd_data_b), 64'hB6B60002);

      op(0, S_CTL, 3);
      chk("R5 dlc", 64'(rd_dlc), 64'd8);
      chk("R5 txie", 64'(rd_txie), 64'd1);

      op(0, S_CLRP | S_CTL, 3);
      chk("R9 pending before clear", 64'(rd_intpnd), 64'd1);
      op(0, S_CTL, 3);
      chk("R9 pending cleared", 64'(rd_intpnd), 64'd0);
      chk("R10 new data untouched by R9 clear", 64'(rd_newdat), 64'd1);

      op(0, S_TXND | S_CTL, 3);
      chk("R10 new data before clear", 64'(rd_newdat), 64'd1);
      op(0, S_CTL, 3);
      chk("R10 new data cleared", 64'(rd_newdat), 64'd0);

      op(1, S_TXND | S_CLRP, 5);
      chk("R7 txrq raised", 64'(txrq_stat[4]), 64'd1);
      chk("R7 valid not touched", 64'(valid_stat[4]), 64'd0);

      // illegal numbers
      wr_msgval = 1;
      @(negedge clk); cmd_valid = 1; cmd_write = 1; cmd_sel = S_ARB; cmd_num = '0;
      @(negedge clk); chk("R3 number 0 rejected", 64'(busy), 64'd0);
      cmd_num = NW'(NOBJ + 1);
      @(negedge clk); chk("R3 number N+1 rejected", 64'(busy), 64'd0);
      cmd_valid = 0;
      @(negedge clk); chk("R3 store unchanged", 64'(valid_stat), 64'h0104);

      // command held while busy
      @(negedge clk); cmd_valid = 1; cmd_write = 1; cmd_sel = S_ARB; cmd_num = NW'(6);
      @(negedge clk); cmd_num = NW'(7);
      @(negedge clk);
      @(negedge clk); cmd_valid = 0;
      while (busy) @(negedge clk);
      @(negedge clk);
      chk("R2 first command done", 64'(valid_stat[5]), 64'd1);
      chk("R2 busy command ignored", 64'(valid_stat[6]), 64'd0);

      // fill the upper half
      wr_xtd = 0; wr_msgval = 1;
      for (int k = 10; k < NOBJ; k++) op(1, S_ARB, k);
      chk("R12 all used gives N", 64'(free_rx_num), 64'(NOBJ));
      wr_msgval = 0;
      op(1, S_ARB, 12);
      chk("R12 lowest free", 64'(free_rx_num), 64'd12);

      op(0, 7'h00, 12);
      chk("R8 no select keeps data", 64'(rd_data_a), 64'hC3C30003);

      // reset mid-run
      @(negedge clk); rst_n = 0;
      @(negedge clk); @(negedge clk);
      chk("R13 valid cleared", 64'(valid_stat), 64'd0);
      chk("R13 rd cleared", 64'(rd_data_a), 64'd0);
      chk("R13 free reset", 64'(free_rx_num), 64'd9);
      chk("R13 busy reset", 64'(busy), 64'd0);
      finish_run();
   end
endmodule